// File: doc/BRIEF.md
# Accelerator Control Register Slave

This block is an AXI4-Lite slave that sits between a host processor and a hardware kernel. The host starts the kernel, lets it go on after a finished run, enables and acknowledges interrupts, writes the kernel's input arguments and reads back its result. All of this goes through a small register window. Toward the kernel the block drives a start level, a one-cycle continue pulse and the argument values. It takes in the kernel's done, idle and ready signals and a return value.

Several register bits have side effects of their own:
- The start bit drops when the kernel signals ready.
- The ready bit clears when the host reads the control word.
- The continue bit clears itself after one cycle.
- Interrupt status bits flip when the host writes a 1 to them.

A single interrupt line is formed from a global enable, per-source enables and the status bits. Every access gets an OKAY response.

Top module: `kc_ctrl_top`

## Requirements
- R1: A write takes effect only after both the address handshake and the data handshake have happened, in either order or in the same cycle. BVALID then rises and stays high until BREADY. BRESP is always 00 (OKAY).
- R2: RVALID rises on the clock edge after the read-address handshake. RVALID and RDATA hold steady until RREADY is seen high. RRESP is always 00.
- R3: Offsets 0x10, 0x18 and 0x20 hold the 8-bit arguments in bits 7:0. These drive `arg_bus` with the first argument in the lowest byte. Offset 0x28 returns `k_ret` and ignores writes. Reserved offsets such as 0x14 read as zero and ignore writes.
- R4: Control bit 0 (start) drives `k_start`. A write to offset 0x00 loads it from data bit 0, and a high `k_ready` clears it.
- R5: When control bit 7 (auto-restart) is set, a `k_done` pulse sets start again. When bit 7 is clear, `k_done` leaves start unchanged.
- R6: Control bit 1 (done) sets on a `k_done` pulse. Writing 1 to control bit 4 (continue) makes `k_continue` high for exactly one cycle and clears the done bit.
- R7: Control bit 2 reflects `k_idle`. Control bit 3 (ready) latches on a `k_ready` pulse. A read of offset 0x00 returns it and then clears it.
- R8: Interrupt status at offset 0x0C has bit 0 for done and bit 1 for ready. Each bit sets on its kernel pulse, and writing 1 to a bit toggles it.
- R9: `irq` is high one cycle after the global enable (offset 0x04 bit 0) is set and some status bit is set together with its enable bit (offset 0x08, bit 0 for done and bit 1 for ready). Control bit 9 reads the `irq` value, and all unlisted control bits read 0.
- R10: All writable fields sit in byte lane 0. A write whose WSTRB bit 0 is low leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_addr | input | ADDR_W | Write address |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Write byte strobes |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| b_resp | output | 2 | Write response code |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| ar_addr | input | ADDR_W | Read address |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| r_data | output | DATA_W | Read data |
| r_resp | output | 2 | Read response code |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| k_start | output | 1 | Start level to the kernel |
| k_continue | output | 1 | One-cycle continue pulse |
| k_done | input | 1 | Kernel done pulse |
| k_idle | input | 1 | Kernel idle level |
| k_ready | input | 1 | Kernel ready pulse |
| k_ret | input | ARG_W | Kernel return value |
| arg_bus | output | NUM_ARGS*ARG_W | Argument values, first argument lowest |
| irq | output | 1 | Level interrupt |

## Verification
Register effects of a write appear on the second edge after the later of the two handshakes: one edge captures the request and the next commits it. BVALID rises on that same edge, so the bench reads kernel-facing outputs only after the write response has been taken. `irq` follows the status change by one more edge, so interrupt checks are made at least one falling edge later. Read data is captured on the address-handshake edge and sampled at the following falling edge. Kernel pulses are driven for one full cycle between falling edges, and their effect is sampled at the next falling edge.

// File: rtl/kc_ctrl_pkg.sv
`timescale 1ns/1ps
package kc_ctrl_pkg;
  // register window offsets (bytes)
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_GIE    = 'h04;
  localparam int OFF_IER    = 'h08;
  localparam int OFF_ISR    = 'h0C;
  localparam int ARG_BASE   = 'h10;
  localparam int ARG_STRIDE = 8;

  // control word bit positions
  localparam int CB_START = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_IDLE  = 2;
  localparam int CB_READY = 3;
  localparam int CB_CONT  = 4;
  localparam int CB_AUTO  = 7;
  localparam int CB_IRQ   = 9;

  // interrupt source positions
  localparam int IS_DONE  = 0;
  localparam int IS_READY = 1;
  localparam int NUM_SRC  = 2;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/kc_axil_wr.sv
`timescale 1ns/1ps
// Write side: captures address and data independently, commits once both held.
module kc_axil_wr #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_valid,
  output logic              w_ready,
  output logic              b_valid,
  input  logic              b_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic aw_full, w_full;

  assign aw_ready = !aw_full && !b_valid;
  assign w_ready  = !w_full  && !b_valid;
  assign wr_en    = aw_full && w_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      b_valid <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      if (wr_en) begin
        aw_full <= 1'b0;
        w_full  <= 1'b0;
      end else begin
        if (aw_valid && aw_ready) begin
          aw_full <= 1'b1;
          wr_addr <= aw_addr;
        end
        if (w_valid && w_ready) begin
          w_full  <= 1'b1;
          wr_data <= w_data;
          wr_strb <= w_strb;
        end
      end
      if (wr_en)
        b_valid <= 1'b1;
      else if (b_ready)
        b_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kc_arg_bank.sv
`timescale 1ns/1ps
// Argument registers, one per slot, byte-strobed.
module kc_arg_bank
  import kc_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int NUM_ARGS = 3,
  parameter int ARG_W    = 8,
  localparam int STRB_W  = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [STRB_W-1:0]         wr_strb,
  output logic [NUM_ARGS*ARG_W-1:0] arg_bus
);
  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
    localparam int OFF = ARG_BASE + g * ARG_STRIDE;
    logic [ARG_W-1:0] q;
    logic             hit;
    assign hit = (wr_addr[ADDR_W-1:2] == OFF[ADDR_W-1:2]);
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && hit) begin
        for (int b = 0; b < ARG_W; b++)
          if (wr_strb[b/8]) q[b] <= wr_data[b];
      end
    end
    assign arg_bus[g*ARG_W +: ARG_W] = q;
  end
endmodule

// File: rtl/kc_ctrl_core.sv
`timescale 1ns/1ps
// Control word, interrupt enables/status and the interrupt line.
module kc_ctrl_core
  import kc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [STRB_W-1:0]  wr_strb,
  input  logic               rd_ctrl,
  input  logic               k_done,
  input  logic               k_idle,
  input  logic               k_ready,
  output logic               k_start,
  output logic               k_continue,
  output logic               gie,
  output logic [NUM_SRC-1:0] ier,
  output logic [NUM_SRC-1:0] isr,
  output logic               irq,
  output logic [DATA_W-1:0]  ctrl_word
);
  logic done_q, idle_q, ready_q, auto_q;
  logic wr_ctrl, wr_gie, wr_ier, wr_isr;
  logic [NUM_SRC-1:0] ev, flip;

  assign wr_ctrl = wr_en && wr_strb[0] && (wr_addr[ADDR_W-1:2] == OFF_CTRL[ADDR_W-1:2]);
  assign wr_gie  = wr_en && wr_strb[0] && (wr_addr[ADDR_W-1:2] == OFF_GIE[ADDR_W-1:2]);
  assign wr_ier  = wr_en && wr_strb[0] && (wr_addr[ADDR_W-1:2] == OFF_IER[ADDR_W-1:2]);
  assign wr_isr  = wr_en && wr_strb[0] && (wr_addr[ADDR_W-1:2] == OFF_ISR[ADDR_W-1:2]);

  always_comb begin
    ev = '0;
    ev[IS_DONE]  = k_done;
    ev[IS_READY] = k_ready;
    flip = wr_isr ? wr_data[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_start    <= 1'b0;
      k_continue <= 1'b0;
      done_q     <= 1'b0;
      idle_q     <= 1'b0;
      ready_q    <= 1'b0;
      auto_q     <= 1'b0;
      gie        <= 1'b0;
      ier        <= '0;
      isr        <= '0;
      irq        <= 1'b0;
    end else begin
      // host write beats auto-restart, which beats the ready handshake clear
      if (wr_ctrl)                k_start <= wr_data[CB_START];
      else if (k_done && auto_q)  k_start <= 1'b1;
      else if (k_ready)           k_start <= 1'b0;

      k_continue <= wr_ctrl && wr_data[CB_CONT];

      if (k_done)                          done_q <= 1'b1;
      else if (wr_ctrl && wr_data[CB_CONT]) done_q <= 1'b0;

      if (k_ready)      ready_q <= 1'b1;
      else if (rd_ctrl) ready_q <= 1'b0;

      if (wr_ctrl) auto_q <= wr_data[CB_AUTO];
      if (wr_gie)  gie    <= wr_data[0];
      if (wr_ier)  ier    <= wr_data[NUM_SRC-1:0];

      idle_q <= k_idle;
      isr    <= (isr ^ flip) | ev;
      irq    <= gie && |(isr & ier);
    end
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CB_START] = k_start;
    ctrl_word[CB_DONE]  = done_q;
    ctrl_word[CB_IDLE]  = idle_q;
    ctrl_word[CB_READY] = ready_q;
    ctrl_word[CB_CONT]  = k_continue;
    ctrl_word[CB_AUTO]  = auto_q;
    ctrl_word[CB_IRQ]   = irq;
  end
endmodule

// File: rtl/kc_ctrl_top.sv
`timescale 1ns/1ps
module kc_ctrl_top
  import kc_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int NUM_ARGS = 3,
  parameter int ARG_W    = 8,
  localparam int STRB_W  = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         aw_addr,
  input  logic                      aw_valid,
  output logic                      aw_ready,
  input  logic [DATA_W-1:0]         w_data,
  input  logic [STRB_W-1:0]         w_strb,
  input  logic                      w_valid,
  output logic                      w_ready,
  output logic [1:0]                b_resp,
  output logic                      b_valid,
  input  logic                      b_ready,
  input  logic [ADDR_W-1:0]         ar_addr,
  input  logic                      ar_valid,
  output logic                      ar_ready,
  output logic [DATA_W-1:0]         r_data,
  output logic [1:0]                r_resp,
  output logic                      r_valid,
  input  logic                      r_ready,
  output logic                      k_start,
  output logic                      k_continue,
  input  logic                      k_done,
  input  logic                      k_idle,
  input  logic                      k_ready,
  input  logic [ARG_W-1:0]          k_ret,
  output logic [NUM_ARGS*ARG_W-1:0] arg_bus,
  output logic                      irq
);
  localparam int RET_OFF = ARG_BASE + NUM_ARGS * ARG_STRIDE;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic              rd_fire, rd_ctrl, gie_w;
  logic [NUM_SRC-1:0] ier_w, isr_w;
  logic [DATA_W-1:0] ctrl_word, rd_word;

  kc_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .aw_addr(aw_addr), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_data(w_data), .w_strb(w_strb), .w_valid(w_valid), .w_ready(w_ready),
    .b_valid(b_valid), .b_ready(b_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  kc_ctrl_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_ctrl(rd_ctrl),
    .k_done(k_done), .k_idle(k_idle), .k_ready(k_ready),
    .k_start(k_start), .k_continue(k_continue),
    .gie(gie_w), .ier(ier_w), .isr(isr_w), .irq(irq),
    .ctrl_word(ctrl_word)
  );

  kc_arg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ARGS(NUM_ARGS), .ARG_W(ARG_W)) u_args (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .arg_bus(arg_bus)
  );

  assign b_resp   = RESP_OKAY;
  assign r_resp   = RESP_OKAY;
  assign ar_ready = !r_valid;
  assign rd_fire  = ar_valid && ar_ready;
  assign rd_ctrl  = rd_fire && (ar_addr[ADDR_W-1:2] == OFF_CTRL[ADDR_W-1:2]);

  always_comb begin
    rd_word = '0;
    if (ar_addr[ADDR_W-1:2] == OFF_CTRL[ADDR_W-1:2]) rd_word = ctrl_word;
    if (ar_addr[ADDR_W-1:2] == OFF_GIE[ADDR_W-1:2])  rd_word = DATA_W'(gie_w);
    if (ar_addr[ADDR_W-1:2] == OFF_IER[ADDR_W-1:2])  rd_word = DATA_W'(ier_w);
    if (ar_addr[ADDR_W-1:2] == OFF_ISR[ADDR_W-1:2])  rd_word = DATA_W'(isr_w);
    if (ar_addr[ADDR_W-1:2] == RET_OFF[ADDR_W-1:2])  rd_word = DATA_W'(k_ret);
    for (int i = 0; i < NUM_ARGS; i++) begin
      if (ar_addr[ADDR_W-1:2] == ADDR_W'((ARG_BASE + i * ARG_STRIDE) >> 2))
        rd_word = DATA_W'(arg_bus[i*ARG_W +: ARG_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid <= 1'b0;
      r_data  <= '0;
    end else if (rd_fire) begin
      r_valid <= 1'b1;
      r_data  <= rd_word;
    end else if (r_ready) begin
      r_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kc_ctrl_chk.sv
`timescale 1ns/1ps
module kc_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              b_valid,
  input logic              b_ready,
  input logic [1:0]        b_resp,
  input logic              r_valid,
  input logic              r_ready,
  input logic [DATA_W-1:0] r_data,
  input logic [1:0]        r_resp,
  input logic              k_continue,
  input logic              gie,
  input logic              irq
);
  p_bvalid_hold_r1: assert property (@(posedge clk) disable iff (rst)
    b_valid && !b_ready |=> b_valid);
  p_bresp_okay_r1: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> b_resp == 2'b00);
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    r_valid && !r_ready |=> r_valid && $stable(r_data));
  p_rresp_okay_r2: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> r_resp == 2'b00);
  p_cont_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    k_continue |=> !k_continue);
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq);
endmodule

bind kc_ctrl_top kc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
  .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
  .k_continue(k_continue), .gie(gie_w), .irq(irq)
);

// File: tb/sim_kc_ctrl_top.sv
`timescale 1ns/1ps
module sim_kc_ctrl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  aw_addr = '0, ar_addr = '0;
  logic        aw_valid = 0, w_valid = 0, b_ready = 0, ar_valid = 0, r_ready = 0;
  logic [31:0] w_data = '0;
  logic [3:0]  w_strb = '0;
  logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
  logic [1:0]  b_resp, r_resp;
  logic [31:0] r_data;
  logic        k_start, k_continue, irq;
  logic        k_done = 0, k_idle = 1, k_ready = 0;
  logic [7:0]  k_ret = 8'h77;
  logic [23:0] arg_bus;

  int checks = 0, errors = 0, cont_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  kc_ctrl_top u0 (
    .clk(clk), .rst(rst),
    .aw_addr(aw_addr), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_data(w_data), .w_strb(w_strb), .w_valid(w_valid), .w_ready(w_ready),
    .b_resp(b_resp), .b_valid(b_valid), .b_ready(b_ready),
    .ar_addr(ar_addr), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_data(r_data), .r_resp(r_resp), .r_valid(r_valid), .r_ready(r_ready),
    .k_start(k_start), .k_continue(k_continue),
    .k_done(k_done), .k_idle(k_idle), .k_ready(k_ready), .k_ret(k_ret),
    .arg_bus(arg_bus), .irq(irq)
  );

  always @(negedge clk) if (!rst && k_continue) cont_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // mode 0: address and data together, 1: address first, 2: data first
  task automatic axi_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s, input int mode);
    bit aw_done = 0, w_done = 0, hs_aw, hs_w, early = 0;
    int cyc = 0;
    while (!(aw_done && w_done)) begin
      aw_addr  = a; w_data = d; w_strb = s;
      aw_valid = !aw_done && (mode != 2 || cyc >= 2);
      w_valid  = !w_done  && (mode != 1 || cyc >= 2);
      hs_aw = aw_valid && aw_ready;
      hs_w  = w_valid && w_ready;
      if (b_valid) early = 1;
      @(negedge clk);
      cyc++;
      if (hs_aw) aw_done = 1;
      if (hs_w)  w_done  = 1;
    end
    aw_valid = 0; w_valid = 0;
    if (b_valid) early = 1;
    b_ready = 1;
    do @(negedge clk); while (!b_valid);
    chk(!early && b_resp == 2'b00, "R1 write response", {29'd0, early, b_resp}, 32'd0);
    @(negedge clk);
    b_ready = 0;
  endtask

  task automatic axi_read(input logic [5:0] a, input int hold, output logic [31:0] d);
    bit stable_ok = 1;
    ar_addr = a; ar_valid = 1;
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = 0;
    d = r_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!r_valid || r_data != d) stable_ok = 0;
    end
    chk(r_valid && stable_ok && r_resp == 2'b00, "R2 read valid/hold", {30'd0, r_resp}, 32'd0);
    r_ready = 1;
    @(negedge clk);
    r_ready = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    axi_read(a, 0, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) k_done = 1; else k_ready = 1;
    @(negedge clk);
    k_done = 0; k_ready = 0;
  endtask

  // {mode[1:0], addr[5:0], data[31:0], strb[3:0], expect[31:0]}
  localparam logic [75:0] VEC [9] = '{
    {2'd0, 6'h10, 32'h0000_005A, 4'h1, 32'h0000_005A},  // R3
    {2'd1, 6'h18, 32'hFFFF_FF3C, 4'hF, 32'h0000_003C},  // R3 R1
    {2'd2, 6'h20, 32'h0000_00C3, 4'h1, 32'h0000_00C3},  // R3 R1
    {2'd0, 6'h20, 32'h0000_0011, 4'h0, 32'h0000_00C3},  // R10
    {2'd0, 6'h10, 32'h0000_01A5, 4'h2, 32'h0000_005A},  // R10
    {2'd1, 6'h08, 32'hFFFF_FFFF, 4'h1, 32'h0000_0003},  // R9 enables
    {2'd2, 6'h04, 32'h0000_0001, 4'h1, 32'h0000_0001},  // R9 global
    {2'd0, 6'h14, 32'h0000_00FF, 4'hF, 32'h0000_0000},  // R3 reserved
    {2'd0, 6'h28, 32'h0000_00FF, 4'hF, 32'h0000_0077}   // R3 return
  };

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!irq && !k_start && !k_continue, "reset outputs", {29'd0, irq, k_start, k_continue}, 32'd0);
    chk(arg_bus == 24'd0 && !b_valid && !r_valid, "reset args/valids", {6'd0, arg_bus, b_valid, r_valid}, 32'd0);
    rd_chk(6'h00, 32'h4, "R7 idle after reset");

    for (int i = 0; i < 9; i++) begin
      axi_write(VEC[i][73:68], VEC[i][67:36], VEC[i][35:32], int'(VEC[i][75:74]));
      rd_chk(VEC[i][73:68], VEC[i][31:0], $sformatf("R3/R10 vector %0d", i));
    end
    chk(arg_bus == 24'hC33C5A, "R3 arg_bus", {8'd0, arg_bus}, 32'h00C33C5A);
    chk(!irq, "R9 no status no irq", {31'd0, irq}, 32'd0);

    // R4 start and ready handshake
    axi_write(6'h00, 32'h1, 4'h1, 0);
    chk(k_start, "R4 start set", {31'd0, k_start}, 32'd1);
    k_idle = 0;
    pulse(1);
    chk(!k_start, "R4 start cleared by ready", {31'd0, k_start}, 32'd0);
    @(negedge clk);
    chk(irq, "R9 irq on ready status", {31'd0, irq}, 32'd1);
    rd_chk(6'h00, 32'h208, "R7 ready latched, R9 irq bit");
    rd_chk(6'h00, 32'h200, "R7 ready cleared on read");
    rd_chk(6'h0C, 32'h2, "R8 ready status set");

    // R8 toggle behaviour
    axi_write(6'h0C, 32'h2, 4'h1, 0);
    @(negedge clk);
    chk(!irq, "R9 irq drops after toggle", {31'd0, irq}, 32'd0);
    rd_chk(6'h0C, 32'h0, "R8 toggle 1->0");
    axi_write(6'h0C, 32'h1, 4'h1, 0);
    @(negedge clk);
    chk(irq, "R8 toggle 0->1 raises irq", {31'd0, irq}, 32'd1);
    axi_write(6'h04, 32'h0, 4'h1, 0);
    @(negedge clk);
    chk(!irq, "R9 global enable off", {31'd0, irq}, 32'd0);
    axi_write(6'h0C, 32'h1, 4'h1, 0);
    rd_chk(6'h0C, 32'h0, "R8 toggle clears done status");

    // R5 auto-restart
    axi_write(6'h00, 32'h80, 4'h1, 0);
    pulse(0);
    chk(k_start, "R5 auto-restart sets start", {31'd0, k_start}, 32'd1);
    rd_chk(6'h00, 32'h83, "R5/R6 auto, done, start");
    rd_chk(6'h0C, 32'h1, "R8 done status set");

    // R6 continue
    cont_cnt = 0;
    axi_write(6'h00, 32'h90, 4'h1, 0);
    repeat (3) @(negedge clk);
    chk(cont_cnt == 1, "R6 continue one cycle", cont_cnt, 32'd1);
    rd_chk(6'h00, 32'h80, "R6 done cleared by continue");

    // R5 without auto-restart
    axi_write(6'h00, 32'h0, 4'h1, 0);
    pulse(0);
    chk(!k_start, "R5 no restart when auto clear", {31'd0, k_start}, 32'd0);
    rd_chk(6'h00, 32'h2, "R6 done bit set");

    // R2 back-pressure on read data
    axi_read(6'h10, 3, d);
    chk(d == 32'h5A, "R2 held read data", d, 32'h5A);

    // R10 control write with lane 0 disabled
    axi_write(6'h00, 32'h1, 4'hE, 0);
    chk(!k_start, "R10 masked control write", {31'd0, k_start}, 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule